// File: doc/BRIEF.md
# Three-Reel Slot Machine Controller

This block runs a three-reel slot machine game. Each reel holds a symbol value from 0 to 7 and shows it on its own seven-segment digit. The player has one push button. The first press sets all three reels spinning. Each reel steps at its own rate, so the reels drift apart from one another. A second press starts a staged stop: reel 1 freezes first, then reel 2, then reel 3. Each freeze comes after a fixed number of clock cycles.

Once the last reel is frozen, the block enters its end state. It raises the win flag if all three values are equal. A further press returns the block to idle with the last values still on the digits, ready for the next game. The raw key is synchronised and debounced, and only a press edge counts. The three digits share one set of segment lines and are scanned in turn.

Top module: `slot_game_top`

## Requirements
- R1: While reset is low (active-low) and on the first cycle after it, gameState is 000, all three reel values are 0, win is 0 and digitSel is 001.
- R2: A debounced press while gameState is 000 (idle) moves gameState to 001 (spin), and from then on all three reels step.
- R3: A running reel k (k = 1, 2, 3) steps exactly once every DIVk clock cycles. Each step adds 1 modulo 8, so 7 goes to 0. A reel that is not running holds its value.
- R4: A press in spin moves gameState to 010. Each of the states 010, 011 and 100 lasts exactly STOP_WAIT cycles and is then followed by the next, ending in 101. Reel 1 runs only in 001 and 010, reel 2 only in 001 to 011, and reel 3 only in 001 to 100.
- R5: gameState only ever takes the values 000 to 101. Every change goes from the current value to the next one in the cycle 000, 001, 010, 011, 100, 101, 000.
- R6: win is 1 exactly when gameState is 101 and all three reel values are equal. Otherwise it is 0.
- R7: Presses while gameState is 010, 011 or 100 have no effect on the state sequence or its timing.
- R8: A press in 101 returns gameState to 000 and leaves the three reel values unchanged.
- R9: A key level change is accepted only after it has been stable for DEB_CYCLES consecutive cycles after a two-stage synchroniser. A pulse shorter than that is ignored. A key held down acts only once.
- R10: digitSel is always one-hot. It rotates 001 (reel 1), 010 (reel 2), 100 (reel 3), and each value is held for REFRESH_CYCLES cycles. segOut is the pattern of the selected reel, active-high, with bit 0 = segment a through bit 6 = segment g: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07 (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| keyRaw | input | 1 | Raw push button, high while pressed |
| reel1 | output | 3 | Value of reel 1 |
| reel2 | output | 3 | Value of reel 2 |
| reel3 | output | 3 | Value of reel 3 |
| gameState | output | 3 | Current control state, encoded 000 to 101 |
| segOut | output | 7 | Segment pattern of the scanned digit, bit 0 = a |
| digitSel | output | 3 | One-hot digit enable, bit 0 = reel 1 |
| win | output | 1 | High in the end state when all reels match |

## Verification
A key change reaches gameState about DEB_CYCLES + 3 edges after keyRaw moves: two synchroniser stages, the debounce count and the press pulse. Because of this, the bench holds the key and polls gameState at falling edges rather than waiting a fixed count. A reel value changes on the edge that ends its divider period, and it is checked at the falling edge that follows, against the state sampled one cycle earlier. The win flag and segOut are combinational from registered values, so they are compared against bench-computed values in the same falling-edge sample. Each stop-state dwell and each digit hold is measured as a count of falling-edge samples between changes.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int unsigned NUM_REELS = 3;
  localparam int unsigned SYM_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SPIN    = 3'd1,
    ST_HALT123 = 3'd2,
    ST_HALT23  = 3'd3,
    ST_HALT3   = 3'd4,
    ST_DONE    = 3'd5
  } gameState_t;

  typedef struct packed {
    logic [NUM_REELS-1:0] run;
    logic                 showResult;
  } reelCtrl_t;

  function automatic logic [6:0] segOf(input logic [SYM_W-1:0] v);
    case (v)
      3'd0: segOf = 7'h3F;
      3'd1: segOf = 7'h06;
      3'd2: segOf = 7'h5B;
      3'd3: segOf = 7'h4F;
      3'd4: segOf = 7'h66;
      3'd5: segOf = 7'h6D;
      3'd6: segOf = 7'h7D;
      default: segOf = 7'h07;
    endcase
  endfunction
endpackage

// File: rtl/slot_debounce.sv
module slot_debounce #(
  parameter int unsigned DEB_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic keyRaw,
  output logic keyPress
);
  localparam int unsigned CW = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [1:0]    syncQ;
  logic          stableLvl;
  logic [CW-1:0] debCnt;
  logic          keySync;

  assign keySync = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      stableLvl <= 1'b0;
      debCnt    <= '0;
      keyPress  <= 1'b0;
    end else begin
      syncQ    <= {syncQ[0], keyRaw};
      keyPress <= 1'b0;
      if (keySync != stableLvl) begin
        if (debCnt == LAST) begin
          stableLvl <= keySync;
          debCnt    <= '0;
          keyPress  <= keySync;
        end else begin
          debCnt <= debCnt + 1'b1;
        end
      end else begin
        debCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl import slot_pkg::*; #(
  parameter int unsigned STOP_WAIT = 25_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyPress,
  output gameState_t state,
  output reelCtrl_t  strobes
);
  localparam int unsigned WW = (STOP_WAIT > 2) ? $clog2(STOP_WAIT) : 1;
  localparam logic [WW-1:0] WAIT_LAST = WW'(STOP_WAIT - 1);

  logic [WW-1:0] waitCnt;
  logic          haltState;

  assign haltState = (state == ST_HALT123) || (state == ST_HALT23) || (state == ST_HALT3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else if (haltState) begin
      if (waitCnt == WAIT_LAST) begin
        waitCnt <= '0;
        unique case (state)
          ST_HALT123: state <= ST_HALT23;
          ST_HALT23:  state <= ST_HALT3;
          default:    state <= ST_DONE;
        endcase
      end else begin
        waitCnt <= waitCnt + 1'b1;
      end
    end else if (keyPress) begin
      waitCnt <= '0;
      unique case (state)
        ST_IDLE: state <= ST_SPIN;
        ST_SPIN: state <= ST_HALT123;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.run[0]     = (state == ST_SPIN) || (state == ST_HALT123);
    strobes.run[1]     = strobes.run[0] || (state == ST_HALT23);
    strobes.run[2]     = strobes.run[1] || (state == ST_HALT3);
    strobes.showResult = (state == ST_DONE);
  end
endmodule

// File: rtl/slot_datapath.sv
module slot_datapath import slot_pkg::*; #(
  parameter int unsigned DIV1           = 10_000_000,
  parameter int unsigned DIV2           = 25_000_000,
  parameter int unsigned DIV3           = 16_666_667,
  parameter int unsigned REFRESH_CYCLES = 16_667
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  reelCtrl_t                        strobes,
  output logic [NUM_REELS-1:0][SYM_W-1:0]  reelBus,
  output logic [6:0]                       segOut,
  output logic [NUM_REELS-1:0]             digitSel,
  output logic                             win
);
  localparam int unsigned RW = (REFRESH_CYCLES > 2) ? $clog2(REFRESH_CYCLES) : 1;
  localparam logic [RW-1:0] REF_LAST = RW'(REFRESH_CYCLES - 1);
  localparam int unsigned IW = $clog2(NUM_REELS);
  localparam logic [IW-1:0] IDX_LAST = IW'(NUM_REELS - 1);

  for (genvar g = 0; g < NUM_REELS; g++) begin : g_reel
    localparam int unsigned PER = (g == 0) ? DIV1 : (g == 1) ? DIV2 : DIV3;
    localparam int unsigned CW  = (PER > 2) ? $clog2(PER) : 1;
    localparam logic [CW-1:0] PER_LAST = CW'(PER - 1);
    logic [CW-1:0] divCnt;
    logic          stepTick;

    assign stepTick = (divCnt == PER_LAST);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        divCnt     <= '0;
        reelBus[g] <= '0;
      end else begin
        divCnt <= stepTick ? '0 : divCnt + 1'b1;
        if (stepTick && strobes.run[g]) reelBus[g] <= reelBus[g] + 1'b1;
      end
    end
  end

  logic [RW-1:0] refCnt;
  logic [IW-1:0] digIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
      digIdx <= '0;
    end else if (refCnt == REF_LAST) begin
      refCnt <= '0;
      digIdx <= (digIdx == IDX_LAST) ? '0 : digIdx + 1'b1;
    end else begin
      refCnt <= refCnt + 1'b1;
    end
  end

  always_comb begin
    digitSel = '0;
    digitSel[digIdx] = 1'b1;
    segOut = segOf(reelBus[digIdx]);
    win = strobes.showResult && (reelBus[0] == reelBus[1]) && (reelBus[1] == reelBus[2]);
  end
endmodule

// File: rtl/slot_game_top.sv
module slot_game_top import slot_pkg::*; #(
  parameter int unsigned DIV1           = 10_000_000,
  parameter int unsigned DIV2           = 25_000_000,
  parameter int unsigned DIV3           = 16_666_667,
  parameter int unsigned STOP_WAIT      = 25_000_000,
  parameter int unsigned DEB_CYCLES     = 1_000_000,
  parameter int unsigned REFRESH_CYCLES = 16_667
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyRaw,
  output logic [2:0] reel1,
  output logic [2:0] reel2,
  output logic [2:0] reel3,
  output logic [2:0] gameState,
  output logic [6:0] segOut,
  output logic [2:0] digitSel,
  output logic       win
);
  logic                            keyPress;
  gameState_t                      ctrlState;
  reelCtrl_t                       strobes;
  logic [NUM_REELS-1:0][SYM_W-1:0] reelBus;

  slot_debounce #(.DEB_CYCLES(DEB_CYCLES)) i_deb (
    .clk(clk), .rstN(rstN), .keyRaw(keyRaw), .keyPress(keyPress)
  );

  slot_ctrl #(.STOP_WAIT(STOP_WAIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .keyPress(keyPress), .state(ctrlState), .strobes(strobes)
  );

  slot_datapath #(
    .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3), .REFRESH_CYCLES(REFRESH_CYCLES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reelBus(reelBus),
    .segOut(segOut), .digitSel(digitSel), .win(win)
  );

  assign gameState = ctrlState;
  assign reel1 = reelBus[0];
  assign reel2 = reelBus[1];
  assign reel3 = reelBus[2];
endmodule

// File: rtl/slot_game_checker.sv
module slot_game_checker (
  input logic       clk,
  input logic       rstN,
  input logic       keyPress,
  input logic [2:0] gameState,
  input logic [2:0] reel1,
  input logic [2:0] reel2,
  input logic [2:0] reel3,
  input logic [2:0] digitSel,
  input logic       win
);
  p_state_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    gameState <= 3'd5);

  p_idle_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (gameState == 3'd0 && keyPress) |=> gameState == 3'd1);

  p_halt_ignore_r7: assert property (@(posedge clk) disable iff (!rstN)
    (gameState == 3'd2) |=> (gameState == 3'd2 || gameState == 3'd3));

  p_reel1_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (gameState != 3'd1 && gameState != 3'd2) |=> $stable(reel1));

  p_reel3_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (gameState == 3'd5 || gameState == 3'd0) |=> $stable(reel3));

  p_reel_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(reel2) |-> reel2 == $past(reel2) + 3'd1);

  p_win_only_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    win |-> (gameState == 3'd5 && reel1 == reel2 && reel2 == reel3));

  p_digit_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(digitSel) == 1);
endmodule

bind slot_game_top slot_game_checker i_chk (
  .clk(clk), .rstN(rstN), .keyPress(keyPress), .gameState(gameState),
  .reel1(reel1), .reel2(reel2), .reel3(reel3), .digitSel(digitSel), .win(win)
);

// File: tb/test_slot_game_top.sv
module test_slot_game_top;
  localparam int DIV1 = 3, DIV2 = 5, DIV3 = 7;
  localparam int STOP_WAIT = 20, DEB = 4, REFRESH = 4;

  logic clk = 1'b0, rstN = 1'b0, keyRaw = 1'b0;
  logic [2:0] reel1, reel2, reel3, gameState, digitSel;
  logic [6:0] segOut;
  logic win;

  int nChecks = 0, nFails = 0, cyc = 0;
  bit finished = 1'b0, winSeen = 1'b0, monOn = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  slot_game_top #(.DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3), .STOP_WAIT(STOP_WAIT),
    .DEB_CYCLES(DEB), .REFRESH_CYCLES(REFRESH)) i_slot_game_top (
    .clk(clk), .rstN(rstN), .keyRaw(keyRaw), .reel1(reel1), .reel2(reel2),
    .reel3(reel3), .gameState(gameState), .segOut(segOut), .digitSel(digitSel), .win(win));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [6:0] expSeg(input logic [2:0] v);
    logic [6:0] t [8] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07};
    return t[v];
  endfunction

  function automatic bit runs(input int k, input logic [2:0] st);
    return (st >= 3'd1) && (st <= 3'(k + 2));
  endfunction

  function automatic int divOf(input int k);
    return (k == 0) ? DIV1 : (k == 1) ? DIV2 : DIV3;
  endfunction

  // Continuous monitor sampled at falling edges
  logic [2:0] prevSt, prevSel;
  logic [2:0] prevReel [3];
  int lastChg [3];
  bit chgValid [3];
  int dwell, hold;
  bit holdValid;

  always @(negedge clk) begin
    logic [2:0] cur [3];
    cur = '{reel1, reel2, reel3};
    if (monOn) begin
      check(win == (gameState == 3'd5 && reel1 == reel2 && reel2 == reel3), "R6 win", win, -1);
      check($countones(digitSel) == 1, "R10 onehot", digitSel, 1);
      for (int k = 0; k < 3; k++) begin
        if (digitSel == 3'(1 << k))
          check(segOut == expSeg(cur[k]), "R10 segments", segOut, expSeg(cur[k]));
        if (cur[k] != prevReel[k]) begin
          check(cur[k] == prevReel[k] + 3'd1, "R3 step/wrap", cur[k], prevReel[k] + 3'd1);
          check(runs(k, prevSt), "R4 frozen reel moved", k + 1, 0);
          if (chgValid[k]) check(cyc - lastChg[k] == divOf(k), "R3 rate", cyc - lastChg[k], divOf(k));
          lastChg[k] = cyc;
          chgValid[k] = 1'b1;
        end
        if (!runs(k, prevSt)) chgValid[k] = 1'b0;
      end
      if (gameState != prevSt) begin
        check(gameState == ((prevSt == 3'd5) ? 3'd0 : prevSt + 3'd1), "R5 sequence", gameState, prevSt);
        if (prevSt >= 3'd2 && prevSt <= 3'd4) check(dwell == STOP_WAIT, "R4 dwell", dwell, STOP_WAIT);
        dwell = 1;
      end else dwell++;
      if (digitSel != prevSel) begin
        check(digitSel == {prevSel[1:0], prevSel[2]}, "R10 rotation", digitSel, {prevSel[1:0], prevSel[2]});
        if (holdValid) check(hold == REFRESH, "R10 hold", hold, REFRESH);
        holdValid = 1'b1;
        hold = 1;
      end else hold++;
    end else begin
      dwell = 1; hold = 1; holdValid = 1'b0;
      for (int k = 0; k < 3; k++) chgValid[k] = 1'b0;
    end
    prevSt = gameState;
    prevSel = digitSel;
    for (int k = 0; k < 3; k++) prevReel[k] = cur[k];
  end

  task automatic pressUntil(input logic [2:0] target, input string req);
    int n = 0;
    @(negedge clk) keyRaw = 1'b1;
    while (gameState != target && n < 60) begin @(negedge clk); n++; end
    check(gameState == target, req, gameState, target);
    keyRaw = 1'b0;
    repeat (DEB + 4) @(negedge clk);
  endtask

  task automatic waitState(input logic [2:0] target, input string req);
    int n = 0;
    while (gameState != target && n < 400) begin @(negedge clk); n++; end
    check(gameState == target, req, gameState, target);
  endtask

  task automatic playGame(input int spin, input bit extraPress);
    logic [2:0] f1, f2, f3;
    pressUntil(3'd1, "R2 start");
    repeat (spin) @(negedge clk);
    pressUntil(3'd2, "R4 stop begins");
    if (extraPress) begin  // R7: press during halting states
      keyRaw = 1'b1;
      repeat (DEB + 4) @(negedge clk);
      keyRaw = 1'b0;
    end
    waitState(3'd5, "R4 reaches end");
    f1 = reel1; f2 = reel2; f3 = reel3;
    check(win == (f1 == f2 && f2 == f3), "R6 end compare", win, f1 == f2 && f2 == f3);
    if (win) winSeen = 1'b1;
    repeat (10) @(negedge clk);
    check({reel1, reel2, reel3} == {f1, f2, f3}, "R4 held in end", {reel1, reel2, reel3}, {f1, f2, f3});
    pressUntil(3'd0, "R8 back to idle");
    check({reel1, reel2, reel3} == {f1, f2, f3}, "R8 values kept", {reel1, reel2, reel3}, {f1, f2, f3});
    check(win == 1'b0, "R6 no win in idle", win, 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7351));
    repeat (5) @(negedge clk);
    check({gameState, reel1, reel2, reel3, win} == '0, "R1 reset values", gameState, 0);
    check(digitSel == 3'b001, "R1 reset digit", digitSel, 1);
    rstN = 1'b1;
    @(negedge clk);
    check({gameState, reel1, reel2, reel3, win} == '0, "R1 after release", gameState, 0);
    monOn = 1'b1;

    // R9: pulse one cycle shorter than the debounce window is ignored
    keyRaw = 1'b1;
    repeat (DEB - 1) @(negedge clk);
    keyRaw = 1'b0;
    repeat (12) @(negedge clk);
    check(gameState == 3'd0, "R9 short pulse ignored", gameState, 0);

    // R9: long hold acts once only
    keyRaw = 1'b1;
    repeat (60) @(negedge clk);
    check(gameState == 3'd1, "R9 held key single action", gameState, 1);
    keyRaw = 1'b0;
    repeat (DEB + 4) @(negedge clk);
    pressUntil(3'd2, "R4 stop begins");
    waitState(3'd5, "R4 reaches end");
    pressUntil(3'd0, "R8 back to idle");

    playGame(1, 1'b1);
    for (int g = 0; g < 400; g++) begin
      if (g >= 30 && winSeen) break;
      playGame($urandom_range(1, 64), $urandom_range(0, 1) == 1);
    end
    check(winSeen, "R6 winning game observed", winSeen, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule